// File: doc/BRIEF.md
# PCI Inbound Memory Cycle Decoder

This block sits on the target side of a PCI-to-host bridge. At the start of every PCI address phase (the first clock on which FRAME# is seen low after being high), it classifies the bus command as a system-memory read, a system-memory write, or a cycle the bridge does not claim. It also forms the memory address from the PCI address. In the normal case the most significant address bit is inverted, which folds the upper half of the PCI space onto the lower half of memory. A memory cycle whose translated address lands in the lower half is accepted. One that lands in the upper half is flagged for abort.

A one-shot exception serves DMA from a legacy ISA bus master. When the hold request and the ISA-master input are both seen low on the same clock, a pending flag is armed. The next address phase mastered by the I/O bridge then runs with translation suppressed: the address passes through unchanged and a no-translate output is raised. That address phase also clears the pending flag. Address phases from any other master leave the flag alone and are translated normally. All results are registered and appear one clock after the address phase, marked by a one-cycle valid pulse.

Top module: `pci_inbound_decoder`

## Requirements
- R1: `cbe_ni` codes 4'b0110, 4'b1100 and 4'b1110 give `dec_cmd_o` = 2'b01 (memory read) in the decoded result.
- R2: `cbe_ni` codes 4'b0111 and 4'b1111 give `dec_cmd_o` = 2'b10 (memory write).
- R3: Every other `cbe_ni` code gives `dec_cmd_o` = 2'b00, with `in_range_o` = 0 and `abort_o` = 0.
- R4: Without the exception, `mem_addr_o` equals `ad_i` with bit 31 inverted and bits 30:0 unchanged.
- R5: For a memory command, translated bit 31 = 0 sets `in_range_o` = 1 and `abort_o` = 0, and translated bit 31 = 1 sets `abort_o` = 1 and `in_range_o` = 0. This includes a bridge DMA address below 2G that is issued with no armed exception.
- R6: An address phase is the first rising edge on which `frame_ni` is low after an edge on which it was high. Results and a one-cycle `dec_valid_o` pulse appear after that edge. Holding `frame_ni` low does not produce a second decode.
- R7: The exception arms only when `hold_ni` and `isa_master_ni` are both low on the same rising edge. If they are low on different edges, it does not arm.
- R8: With the exception armed, the next address phase that has `bridge_gnt_i` = 1 (of any command) gives `no_trans_o` = 1 and `mem_addr_o` = `ad_i` unchanged, and it disarms the exception.
- R9: An address phase with `bridge_gnt_i` = 0 while the exception is armed is translated normally, with `no_trans_o` = 0, and leaves it armed.
- R10: An arming edge that coincides with a bridge address phase does not affect that phase. The exception is armed afterwards.
- R11: Reset clears all outputs and disarms the exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | PCI FRAME#, active low |
| cbe_ni | input | 4 | Command / byte-enable bus, sampled in the address phase |
| ad_i | input | 32 | PCI address, sampled in the address phase |
| bridge_gnt_i | input | 1 | Current master is the I/O bridge |
| hold_ni | input | 1 | Hold request from the I/O bridge, active low |
| isa_master_ni | input | 1 | ISA bus master active, active low |
| dec_valid_o | output | 1 | One-cycle pulse: decoded result is valid |
| dec_cmd_o | output | 2 | 00 none, 01 memory read, 10 memory write |
| mem_addr_o | output | 32 | Translated memory address |
| no_trans_o | output | 1 | Translation was suppressed for this phase |
| in_range_o | output | 1 | Memory cycle accepted |
| abort_o | output | 1 | Memory cycle to be aborted |

## Verification
The assertions check on every clock the properties that need no knowledge of the command table:
- the valid pulse lasts one cycle;
- accept and abort are never both raised;
- ignored commands raise neither flag;
- translated cycles flip bit 31;
- the armed flag follows its set, hold and clear rules.

The bench scenarios are what show the rest. They exercise every command code, the exact translated addresses, the arming rule when the two inputs are low on different edges, the interleaving of bridge and non-bridge masters while the exception is armed, the coincident arm-and-consume edge, and the effect of reset on the armed flag.

// File: rtl/pci_dec_pkg.sv
package pci_dec_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_MEM_RD = 2'b01,
    CMD_MEM_WR = 2'b10
  } mem_cmd_e;
endpackage

// File: rtl/pci_cmd_decode.sv
module pci_cmd_decode
  import pci_dec_pkg::*;
(
  input  logic [3:0] cbe_ni,
  output mem_cmd_e   cmd_o
);
  always_comb begin
    unique case (cbe_ni)
      4'b0110, 4'b1100, 4'b1110: cmd_o = CMD_MEM_RD;
      4'b0111, 4'b1111:          cmd_o = CMD_MEM_WR;
      default:                   cmd_o = CMD_NONE;
    endcase
  end
endmodule

// File: rtl/pci_addr_xlate.sv
module pci_addr_xlate #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] ad_i,
  input  logic              no_trans_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              in_low_o
);
  localparam int MSB = ADDR_W - 1;

  // top bit flips unless translation is suppressed
  assign addr_o   = {ad_i[MSB] ^ ~no_trans_i, ad_i[MSB-1:0]};
  assign in_low_o = ~addr_o[MSB];
endmodule

// File: rtl/pci_isa_pending.sv
module pci_isa_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_ni,
  input  logic isa_master_ni,
  input  logic consume_i,
  output logic pending_o
);
  logic arm;
  logic pending_q;

  assign arm = ~hold_ni & ~isa_master_ni;

  // a new arm wins over a coincident consume
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= 1'b0;
    else         pending_q <= (pending_q & ~consume_i) | arm;
  end

  assign pending_o = pending_q;

  assert_arm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_ni && !isa_master_ni) |=> pending_q);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && consume_i && (hold_ni || isa_master_ni)) |=> !pending_q);
  assert_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !consume_i) |=> pending_q);
  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_q && (hold_ni || isa_master_ni)) |=> !pending_q);
endmodule

// File: rtl/pci_inbound_decoder.sv
module pci_inbound_decoder
  import pci_dec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [3:0]        cbe_ni,
  input  logic [ADDR_W-1:0] ad_i,
  input  logic              bridge_gnt_i,
  input  logic              hold_ni,
  input  logic              isa_master_ni,
  output logic              dec_valid_o,
  output logic [1:0]        dec_cmd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              no_trans_o,
  output logic              in_range_o,
  output logic              abort_o
);
  localparam int MSB = ADDR_W - 1;

  logic              frame_q;
  logic              addr_phase;
  logic              consume;
  logic              pending;
  logic              skip_xlate;
  mem_cmd_e          cmd;
  logic              is_mem;
  logic [ADDR_W-1:0] xaddr;
  logic              in_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_q <= 1'b1;
    else         frame_q <= frame_ni;
  end

  assign addr_phase = frame_q & ~frame_ni;
  assign consume    = addr_phase & bridge_gnt_i;
  assign skip_xlate = consume & pending;

  pci_isa_pending u_pending (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hold_ni       (hold_ni),
    .isa_master_ni (isa_master_ni),
    .consume_i     (consume),
    .pending_o     (pending)
  );

  pci_cmd_decode u_cmd (
    .cbe_ni (cbe_ni),
    .cmd_o  (cmd)
  );

  pci_addr_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .ad_i       (ad_i),
    .no_trans_i (skip_xlate),
    .addr_o     (xaddr),
    .in_low_o   (in_low)
  );

  assign is_mem = (cmd != CMD_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      dec_cmd_o   <= 2'b00;
      mem_addr_o  <= '0;
      no_trans_o  <= 1'b0;
      in_range_o  <= 1'b0;
      abort_o     <= 1'b0;
    end else begin
      dec_valid_o <= addr_phase;
      dec_cmd_o   <= addr_phase ? cmd : CMD_NONE;
      no_trans_o  <= skip_xlate;
      in_range_o  <= addr_phase & is_mem & in_low;
      abort_o     <= addr_phase & is_mem & ~in_low;
      if (addr_phase) mem_addr_o <= xaddr;
    end
  end

  assert_one_shot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o);
  assert_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_range_o && abort_o));
  assert_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_range_o |-> (dec_valid_o && !mem_addr_o[MSB]));
  assert_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_cmd_o == 2'b00) |-> (!in_range_o && !abort_o));
  assert_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !no_trans_o) |-> (mem_addr_o[MSB] != $past(ad_i[MSB])));
  assert_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_trans_o |-> (dec_valid_o && mem_addr_o == $past(ad_i)));
endmodule

// File: tb/pci_inbound_decoder_test.sv
module pci_inbound_decoder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_ni = 1'b1;
  logic [3:0]  cbe_ni = 4'h0;
  logic [31:0] ad_i = '0;
  logic        bridge_gnt_i = 1'b0;
  logic        hold_ni = 1'b1;
  logic        isa_master_ni = 1'b1;
  logic        dec_valid_o;
  logic [1:0]  dec_cmd_o;
  logic [31:0] mem_addr_o;
  logic        no_trans_o, in_range_o, abort_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pci_inbound_decoder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_ni(frame_ni), .cbe_ni(cbe_ni),
    .ad_i(ad_i), .bridge_gnt_i(bridge_gnt_i), .hold_ni(hold_ni),
    .isa_master_ni(isa_master_ni), .dec_valid_o(dec_valid_o),
    .dec_cmd_o(dec_cmd_o), .mem_addr_o(mem_addr_o), .no_trans_o(no_trans_o),
    .in_range_o(in_range_o), .abort_o(abort_o)
  );

  typedef struct packed {
    logic [3:0]  cbe;
    logic [31:0] ad;
    logic [1:0]  cmd;
    logic [31:0] ma;
    logic        inr;
    logic        abt;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{4'b0110, 32'h8000_1000, 2'b01, 32'h0000_1000, 1'b1, 1'b0},
    '{4'b1100, 32'hFFFF_FFFC, 2'b01, 32'h7FFF_FFFC, 1'b1, 1'b0},
    '{4'b1110, 32'h8123_4560, 2'b01, 32'h0123_4560, 1'b1, 1'b0},
    '{4'b0111, 32'h8000_0000, 2'b10, 32'h0000_0000, 1'b1, 1'b0},
    '{4'b1111, 32'h9ABC_DEF0, 2'b10, 32'h1ABC_DEF0, 1'b1, 1'b0},
    '{4'b0110, 32'h0000_2000, 2'b01, 32'h8000_2000, 1'b0, 1'b1},
    '{4'b0111, 32'h7FFF_FFFC, 2'b10, 32'hFFFF_FFFC, 1'b0, 1'b1},
    '{4'b0000, 32'h8000_0000, 2'b00, 32'h0000_0000, 1'b0, 1'b0},
    '{4'b0001, 32'h8000_0004, 2'b00, 32'h0000_0004, 1'b0, 1'b0},
    '{4'b0010, 32'h8000_0008, 2'b00, 32'h0000_0008, 1'b0, 1'b0},
    '{4'b0011, 32'h0000_000C, 2'b00, 32'h8000_000C, 1'b0, 1'b0},
    '{4'b0100, 32'h8000_0010, 2'b00, 32'h0000_0010, 1'b0, 1'b0},
    '{4'b0101, 32'h8000_0014, 2'b00, 32'h0000_0014, 1'b0, 1'b0},
    '{4'b1000, 32'h8000_0018, 2'b00, 32'h0000_0018, 1'b0, 1'b0},
    '{4'b1001, 32'h8000_001C, 2'b00, 32'h0000_001C, 1'b0, 1'b0},
    '{4'b1010, 32'h8000_0020, 2'b00, 32'h0000_0020, 1'b0, 1'b0},
    '{4'b1011, 32'h8000_0024, 2'b00, 32'h0000_0024, 1'b0, 1'b0},
    '{4'b1101, 32'h8000_0028, 2'b00, 32'h0000_0028, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive an address phase; results are sampled on the following falling edge
  task automatic txn(input logic br, input logic [3:0] c, input logic [31:0] a,
                     input logic arm_too);
    @(negedge clk_i);
    frame_ni = 1'b0; cbe_ni = c; ad_i = a; bridge_gnt_i = br;
    if (arm_too) begin hold_ni = 1'b0; isa_master_ni = 1'b0; end
    @(negedge clk_i);
    frame_ni = 1'b1; bridge_gnt_i = 1'b0; hold_ni = 1'b1; isa_master_ni = 1'b1;
  endtask

  task automatic arm();
    @(negedge clk_i);
    hold_ni = 1'b0; isa_master_ni = 1'b0;
    @(negedge clk_i);
    hold_ni = 1'b1; isa_master_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 valid", dec_valid_o, 0);
    chk("R11 cmd", dec_cmd_o, 0);
    chk("R11 addr", mem_addr_o, 0);
    chk("R11 flags", {no_trans_o, in_range_o, abort_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1..R5 table walk, other master and bridge without exception
    for (int i = 0; i < NV; i++) begin
      txn(i[0], TBL[i].cbe, TBL[i].ad, 1'b0);
      chk("R6 valid", dec_valid_o, 1);
      chk(TBL[i].cmd == 2'b01 ? "R1 cmd" : TBL[i].cmd == 2'b10 ? "R2 cmd" : "R3 cmd",
          dec_cmd_o, TBL[i].cmd);
      chk("R4 addr", mem_addr_o, TBL[i].ma);
      chk("R5 in_range", in_range_o, TBL[i].inr);
      chk("R5 abort", abort_o, TBL[i].abt);
      chk("R8 no_trans", no_trans_o, 0);
    end

    // R6 frame held low: a single decode
    @(negedge clk_i);
    frame_ni = 1'b0; cbe_ni = 4'b0110; ad_i = 32'h8000_0040;
    @(negedge clk_i);
    chk("R6 first", dec_valid_o, 1);
    @(negedge clk_i);
    chk("R6 no repeat", dec_valid_o, 0);
    frame_ni = 1'b1;

    // R7 inputs low on different edges do not arm
    @(negedge clk_i); hold_ni = 1'b0;
    @(negedge clk_i); hold_ni = 1'b1; isa_master_ni = 1'b0;
    @(negedge clk_i); isa_master_ni = 1'b1;
    txn(1'b1, 4'b0110, 32'h0000_3000, 1'b0);
    chk("R7 no arm", no_trans_o, 0);
    chk("R7 addr", mem_addr_o, 32'h8000_3000);
    chk("R5 DMA abort", abort_o, 1);

    // R9 other master while armed; then R8 bridge consumes
    arm();
    txn(1'b0, 4'b0111, 32'h8000_5000, 1'b0);
    chk("R9 no_trans", no_trans_o, 0);
    chk("R9 addr", mem_addr_o, 32'h0000_5000);
    txn(1'b1, 4'b0110, 32'h0012_3400, 1'b0);
    chk("R8 no_trans", no_trans_o, 1);
    chk("R8 addr", mem_addr_o, 32'h0012_3400);
    chk("R8 in_range", in_range_o, 1);
    txn(1'b1, 4'b0110, 32'h0012_3400, 1'b0);
    chk("R8 cleared", no_trans_o, 0);
    chk("R8 cleared addr", mem_addr_o, 32'h8012_3400);

    // R8 an ignored command from the bridge also consumes
    arm();
    txn(1'b1, 4'b0010, 32'h0000_0100, 1'b0);
    chk("R8 ign flag", no_trans_o, 1);
    chk("R8 ign cmd", dec_cmd_o, 0);
    txn(1'b1, 4'b0111, 32'h0000_0100, 1'b0);
    chk("R8 ign consumed", no_trans_o, 0);

    // R10 arm coinciding with a bridge address phase
    txn(1'b1, 4'b0111, 32'h0000_0200, 1'b1);
    chk("R10 same edge", no_trans_o, 0);
    txn(1'b1, 4'b0111, 32'h0000_0200, 1'b0);
    chk("R10 armed after", no_trans_o, 1);
    chk("R10 addr", mem_addr_o, 32'h0000_0200);

    // R11 reset disarms
    arm();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R11 mid valid", dec_valid_o, 0);
    rst_ni = 1'b1;
    txn(1'b1, 4'b0110, 32'h0000_0300, 1'b0);
    chk("R11 disarmed", no_trans_o, 0);
    chk("R11 addr", mem_addr_o, 32'h8000_0300);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule